// File: doc/BRIEF.md
# SFDP Flash Geometry Discovery Engine

After reset, this block works out the page size and byte capacity of a serial NOR flash. It reads the flash's discoverable-parameter area through a generic byte-level SPI command port. First it checks the signature. Then it walks the list of parameter headers and picks the newest compatible basic parameter table. Finally it decodes the geometry from that table, using the rules that apply to the table's revision.

The engine runs once and does not restart until the next reset. While it runs, the geometry outputs hold their parameterised defaults. If discovery succeeds, the engine loads the decoded values and raises `cfg_valid`. If the signature is wrong, no table is compatible, or the capacity does not fit in 32 bits, it raises `cfg_error` and the defaults stay in place.

Each read asks the SPI port for one 32-bit word. The request carries a fixed opcode, a 24-bit address, one dummy byte and a length of four bytes. The four returned bytes are assembled least significant byte first.

Top module: `sfdp_geom_discover`

## Requirements
- R1: While reset is held, `page_size` equals DEF_PAGE_SIZE, `capacity` equals DEF_CAPACITY, and `cfg_valid`, `cfg_error` and `xfer_req` are all 0.
- R2: Every request has `xfer_opcode` = 0x5A, `xfer_dummy` = 1 and `xfer_len` = 4. `xfer_req` and `xfer_addr` hold steady until the cycle in which `xfer_ack` is seen, and `xfer_req` drops in the cycle after that. Only one request is outstanding at a time: the next request does not start until four `rx_valid` bytes have been taken.
- R3: The first read is at address 0. That word must equal 0x50444653, assembled with the first byte received in bits [7:0]. Any other value ends the run with `cfg_error` = 1 after exactly one transaction.
- R4: The second read is at address 4. Its bits [7:0] give the header-area minor revision, bits [15:8] its major revision, and bits [23:16] a header count whose true value is one more than the field. Header k (k from 0) is then read as two words, at 8+8k and at 12+8k.
- R5: A header is a basic-table candidate only if the header-area major revision is 1 and bits [7:0] of its first word are 0x00. When the header-area minor revision is 5 or more, bits [31:24] of its second word must also be 0xFF. When the minor revision is below 5, those bits are ignored.
- R6: A candidate is used only if its table major revision (first word bits [23:16]) is 1. A candidate whose table minor revision (bits [15:8]) is lower than the best found so far is skipped. A later candidate with an equal or higher revision replaces the earlier one. The table pointer is bits [23:0] of the header's second word. If no candidate is found, `cfg_error` = 1.
- R7: For a chosen table minor revision below 5, `page_size` is 64 when bit 2 of table word 1 (address pointer+0) is set, and 1 when it is clear. Words 1 and 2 are read, and the run ends after them.
- R8: For a chosen table minor revision of 5 or more, a third read is made at pointer+40 (word 11). `page_size` is 2 raised to bits [7:4] of that word.
- R9: Table word 2 (pointer+4) with bit 31 clear gives `capacity` = (bits[30:0] >> 3) + 1.
- R10: Table word 2 with bit 31 set gives `capacity` = 2^(N-3), where N is bits [30:0]. If N is above 34 or below 3, `cfg_error` = 1 and the defaults stay.
- R11: `cfg_valid` and `cfg_error` are never both 1. Once either is set, no further request is made and all outputs hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | output | 1 | Read request to the SPI command port |
| xfer_opcode | output | 8 | Command opcode, always 0x5A |
| xfer_addr | output | 24 | Byte address of the word to read |
| xfer_dummy | output | 1 | One dummy byte follows the address |
| xfer_len | output | 3 | Number of data bytes to return (4) |
| xfer_ack | input | 1 | Port has accepted the request |
| rx_valid | input | 1 | A returned data byte is present |
| rx_byte | input | 8 | Returned data byte |
| page_size | output | 32 | Page size in bytes |
| capacity | output | 32 | Capacity in bytes |
| cfg_valid | output | 1 | Discovery finished with decoded geometry |
| cfg_error | output | 1 | Discovery failed; defaults kept |

## Verification
The checker assumes the SPI port follows the handshake. It answers a request with one `xfer_ack` pulse and only then returns exactly four bytes, never asserting `rx_valid` in the acknowledge cycle or between transactions. The bench's flash model honours this contract: it acknowledges only a pending request, sends exactly four bytes from its image, and may insert idle cycles before the acknowledge and between bytes. Because stray `rx_valid` pulses outside a transaction are never produced, the engine's byte counting is exercised only within the agreed protocol.

// File: rtl/sfdp_geom_discover.sv
module sfdp_geom_discover #(
  parameter logic [31:0] DEF_PAGE_SIZE = 32'd256,
  parameter logic [31:0] DEF_CAPACITY  = 32'h0010_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        xfer_req,
  output logic [7:0]  xfer_opcode,
  output logic [23:0] xfer_addr,
  output logic        xfer_dummy,
  output logic [2:0]  xfer_len,
  input  logic        xfer_ack,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic [31:0] page_size,
  output logic [31:0] capacity,
  output logic        cfg_valid,
  output logic        cfg_error
);
  localparam logic [31:0] SIG = 32'h5044_4653;

  typedef enum logic [2:0] {
    ST_HDR1, ST_HDR2, ST_PH1, ST_PH2, ST_T1, ST_T2, ST_T11, ST_DONE
  } st_e;

  st_e         state;
  logic        coll;
  logic [1:0]  bcnt;
  logic [23:0] shreg;
  logic [7:0]  sfdp_minor, sfdp_major;
  logic [8:0]  hdr_left;
  logic [23:0] ph_off;
  logic [7:0]  ph_lsb, ph_minor, ph_major;
  logic        found;
  logic [7:0]  best_minor;
  logic [23:0] tbl_ptr;
  logic [31:0] pg_new, cap_new;

  wire [31:0] word      = {rx_byte, shreg};
  wire        word_done = coll && rx_valid && (bcnt == 2'd3);
  wire        id_ok     = (sfdp_major == 8'd1) && (ph_lsb == 8'h00) &&
                          ((sfdp_minor < 8'd5) || (word[31:24] == 8'hFF));
  wire        take      = id_ok && (ph_major == 8'd1) && (ph_minor >= best_minor);
  wire        big_bad   = (word[30:0] > 31'd34) || (word[30:0] < 31'd3);
  wire [31:0] cap_dec   = word[31] ? (32'd1 << (word[4:0] - 5'd3))
                                   : ({1'b0, word[30:0]} >> 3) + 32'd1;

  assign xfer_opcode = 8'h5A;
  assign xfer_dummy  = 1'b1;
  assign xfer_len    = 3'd4;

  always_comb begin
    case (state)
      ST_HDR2: xfer_addr = 24'd4;
      ST_PH1:  xfer_addr = ph_off;
      ST_PH2:  xfer_addr = ph_off + 24'd4;
      ST_T1:   xfer_addr = tbl_ptr;
      ST_T2:   xfer_addr = tbl_ptr + 24'd4;
      ST_T11:  xfer_addr = tbl_ptr + 24'd40;
      default: xfer_addr = 24'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HDR1;
      xfer_req   <= 1'b0;
      coll       <= 1'b0;
      bcnt       <= 2'd0;
      shreg      <= '0;
      sfdp_minor <= '0;
      sfdp_major <= '0;
      hdr_left   <= '0;
      ph_off     <= '0;
      ph_lsb     <= '0;
      ph_minor   <= '0;
      ph_major   <= '0;
      found      <= 1'b0;
      best_minor <= '0;
      tbl_ptr    <= '0;
      pg_new     <= '0;
      cap_new    <= '0;
      page_size  <= DEF_PAGE_SIZE;
      capacity   <= DEF_CAPACITY;
      cfg_valid  <= 1'b0;
      cfg_error  <= 1'b0;
    end else begin
      if (xfer_req) begin
        if (xfer_ack) begin
          xfer_req <= 1'b0;
          coll     <= 1'b1;
          bcnt     <= 2'd0;
        end
      end else if (!coll && state != ST_DONE) begin
        xfer_req <= 1'b1;
      end

      if (coll && rx_valid) begin
        shreg <= {rx_byte, shreg[23:8]};
        bcnt  <= bcnt + 2'd1;
      end

      if (word_done) begin
        coll <= 1'b0;
        case (state)
          ST_HDR1: begin
            if (word == SIG) state <= ST_HDR2;
            else begin cfg_error <= 1'b1; state <= ST_DONE; end
          end
          ST_HDR2: begin
            sfdp_minor <= word[7:0];
            sfdp_major <= word[15:8];
            hdr_left   <= {1'b0, word[23:16]} + 9'd1;
            ph_off     <= 24'd8;
            state      <= ST_PH1;
          end
          ST_PH1: begin
            ph_lsb   <= word[7:0];
            ph_minor <= word[15:8];
            ph_major <= word[23:16];
            state    <= ST_PH2;
          end
          ST_PH2: begin
            if (take) begin
              found      <= 1'b1;
              best_minor <= ph_minor;
              tbl_ptr    <= word[23:0];
            end
            hdr_left <= hdr_left - 9'd1;
            ph_off   <= ph_off + 24'd8;
            if (hdr_left != 9'd1) state <= ST_PH1;
            else if (found || take) state <= ST_T1;
            else begin cfg_error <= 1'b1; state <= ST_DONE; end
          end
          ST_T1: begin
            pg_new <= word[2] ? 32'd64 : 32'd1;
            state  <= ST_T2;
          end
          ST_T2: begin
            if (word[31] && big_bad) begin
              cfg_error <= 1'b1;
              state     <= ST_DONE;
            end else if (best_minor >= 8'd5) begin
              cap_new <= cap_dec;
              state   <= ST_T11;
            end else begin
              page_size <= pg_new;
              capacity  <= cap_dec;
              cfg_valid <= 1'b1;
              state     <= ST_DONE;
            end
          end
          ST_T11: begin
            page_size <= 32'd1 << word[7:4];
            capacity  <= cap_new;
            cfg_valid <= 1'b1;
            state     <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfdp_geom_discover_chk.sv
module sfdp_geom_discover_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xfer_req,
  input logic        xfer_ack,
  input logic [7:0]  xfer_opcode,
  input logic [23:0] xfer_addr,
  input logic        xfer_dummy,
  input logic [2:0]  xfer_len,
  input logic [31:0] page_size,
  input logic [31:0] capacity,
  input logic        cfg_valid,
  input logic        cfg_error
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_addr));
  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_ack |=> !xfer_req);
  // R2
  req_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_opcode == 8'h5A) && xfer_dummy && (xfer_len == 3'd4));
  // R11
  excl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_error));
  // R11
  quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid || cfg_error) |-> !xfer_req);
  // R11
  hold_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid || cfg_error) |=> $stable(page_size) && $stable(capacity) &&
                                  $stable(cfg_valid) && $stable(cfg_error));
endmodule

bind sfdp_geom_discover sfdp_geom_discover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
  .xfer_opcode(xfer_opcode), .xfer_addr(xfer_addr), .xfer_dummy(xfer_dummy),
  .xfer_len(xfer_len), .page_size(page_size), .capacity(capacity),
  .cfg_valid(cfg_valid), .cfg_error(cfg_error)
);

// File: tb/sfdp_geom_discover_bench.sv
module sfdp_geom_discover_bench;
  localparam logic [31:0] DEFP = 32'd256;
  localparam logic [31:0] DEFC = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_ack = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic xfer_req, xfer_dummy, cfg_valid, cfg_error;
  logic [7:0] xfer_opcode;
  logic [23:0] xfer_addr;
  logic [2:0] xfer_len;
  logic [31:0] page_size, capacity;

  always #5 clk = ~clk;

  sfdp_geom_discover #(.DEF_PAGE_SIZE(DEFP), .DEF_CAPACITY(DEFC)) u_sfdp_geom_discover (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_opcode(xfer_opcode),
    .xfer_addr(xfer_addr), .xfer_dummy(xfer_dummy), .xfer_len(xfer_len),
    .xfer_ack(xfer_ack), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .page_size(page_size), .capacity(capacity),
    .cfg_valid(cfg_valid), .cfg_error(cfg_error));

  int nchk = 0, nfail = 0;
  logic [7:0] img [0:255];
  logic [23:0] alog [0:15];
  int ntr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) img[a+i] = v[8*i +: 8];
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    put(0, 32'h5044_4653);
  endtask

  task automatic discover(input bit gap);
    int left, idx;
    bit flip, dly, fmt_ok;
    logic [23:0] a;
    left = 0; idx = 0; flip = 0; dly = 0; fmt_ok = 1; ntr = 0; a = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      xfer_ack = 1'b0; rx_valid = 1'b0;
      if (cfg_valid || cfg_error) break;
      if (left > 0) begin
        if (gap && flip) flip = 0;
        else begin
          rx_valid = 1'b1; rx_byte = img[a[7:0] + 8'(idx)];
          idx++; left--; flip = 1;
        end
      end else if (xfer_req) begin
        if (gap && !dly) dly = 1;
        else begin
          xfer_ack = 1'b1; a = xfer_addr; left = 4; idx = 0; dly = 0;
          if (ntr < 16) alog[ntr] = a;
          ntr++;
          if (xfer_opcode != 8'h5A || !xfer_dummy || xfer_len != 3'd4) fmt_ok = 0;
        end
      end
    end
    xfer_ack = 1'b0; rx_valid = 1'b0;
    chk(fmt_ok, "R2 request format", {xfer_opcode, 21'd0, xfer_len}, {8'h5A, 24'd4});
  endtask

  task automatic expect_ok(input string tag, input logic [31:0] pg, input logic [31:0] cap, input int nt);
    chk(cfg_valid && !cfg_error, {tag, " valid"}, {30'd0, cfg_valid, cfg_error}, 32'd2);
    chk(page_size == pg, {tag, " page_size"}, page_size, pg);
    chk(capacity == cap, {tag, " capacity"}, capacity, cap);
    chk(ntr == nt, {tag, " transactions"}, ntr, nt);
  endtask

  task automatic expect_err(input string tag, input int nt);
    chk(cfg_error && !cfg_valid, {tag, " error"}, {30'd0, cfg_valid, cfg_error}, 32'd1);
    chk(page_size == DEFP && capacity == DEFC, {tag, " defaults"}, capacity, DEFC);
    chk(ntr == nt, {tag, " transactions"}, ntr, nt);
  endtask

  task automatic legacy_tbl(input int ptr, input logic [31:0] d1, input logic [31:0] d2);
    put(ptr, d1); put(ptr + 4, d2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(page_size == DEFP, "R1 reset page_size", page_size, DEFP);
    chk(capacity == DEFC, "R1 reset capacity", capacity, DEFC);
    chk(!cfg_valid && !cfg_error && !xfer_req, "R1 reset flags",
        {29'd0, cfg_valid, cfg_error, xfer_req}, 32'd0);
  endtask

  task automatic t_legacy64(input bit gap);
    clear_img();
    put(4, 32'hFF00_0100);
    put(8, 32'h0901_0000); put(12, 32'hFF00_0030);
    legacy_tbl(32'h30, 32'h0000_0004, 32'h00FF_FFFF);
    discover(gap);
    expect_ok(gap ? "R7 R9 gapped" : "R7 R9 legacy 64", 32'd64, 32'h0020_0000, 6);
    chk(alog[0] == 0 && alog[1] == 4, "R3 R4 header addresses", {alog[0][15:0], alog[1][15:0]}, 32'h0000_0004);
    chk(alog[2] == 8 && alog[3] == 12, "R4 parameter header addresses", {alog[2][15:0], alog[3][15:0]}, 32'h0008_000C);
    chk(alog[4] == 24'h30 && alog[5] == 24'h34, "R7 table addresses", {alog[4][15:0], alog[5][15:0]}, 32'h0030_0034);
  endtask

  task automatic t_legacy1();
    clear_img();
    put(4, 32'hFF00_0100);
    put(8, 32'h0901_0000); put(12, 32'hFF00_0030);
    legacy_tbl(32'h30, 32'hFFFF_FFFB, 32'h0000_0007);
    discover(0);
    expect_ok("R7 R9 legacy 1", 32'd1, 32'd1, 6);
  endtask

  task automatic t_newrev();
    clear_img();
    put(4, 32'hFF01_0106);
    put(8, 32'h0901_0000);  put(12, 32'hFF00_0040);
    put(16, 32'h1001_0600); put(20, 32'hFF00_0080);
    legacy_tbl(32'h40, 32'h0, 32'h0000_00FF);
    legacy_tbl(32'h80, 32'h0, 32'h8000_001B);
    put(32'hA8, 32'h0000_0080);
    discover(0);
    expect_ok("R8 R10 new revision", 32'd256, 32'h0100_0000, 9);
    chk(alog[8] == 24'hA8, "R8 word 11 address", alog[8], 32'hA8);
  endtask

  task automatic t_order();
    clear_img();
    put(4, 32'hFF03_0106);
    put(8, 32'h1001_0600);  put(12, 32'hFF00_0040);
    put(16, 32'h1001_0000); put(20, 32'hFF00_0060);
    put(24, 32'h1001_0600); put(28, 32'hFF00_0080);
    put(32, 32'h1002_0900); put(36, 32'hFF00_0060);
    legacy_tbl(32'h40, 32'h0, 32'h0000_00FF); put(32'h68, 32'h0000_0020);
    legacy_tbl(32'h60, 32'h0, 32'h0000_00FF); put(32'h88, 32'h0000_0020);
    legacy_tbl(32'h80, 32'h0, 32'h8000_0022); put(32'hA8, 32'h0000_0090);
    discover(0);
    expect_ok("R6 R10 later equal wins", 32'd512, 32'h8000_0000, 13);
  endtask

  task automatic t_id_new();
    clear_img();
    put(4, 32'hFF01_0106);
    put(8, 32'h1001_0700);  put(12, 32'h1200_0060);
    put(16, 32'h1001_0600); put(20, 32'hFF00_0080);
    legacy_tbl(32'h60, 32'h0, 32'h0000_00FF); put(32'h88, 32'h0000_0020);
    legacy_tbl(32'h80, 32'h0, 32'h8000_001B); put(32'hA8, 32'h0000_0080);
    discover(0);
    expect_ok("R5 msb checked at rev 6", 32'd256, 32'h0100_0000, 9);
  endtask

  task automatic t_id_old();
    clear_img();
    put(4, 32'hFF01_0100);
    put(8, 32'h0901_0000);  put(12, 32'h1200_0030);
    put(16, 32'h0901_0301); put(20, 32'hFF00_0060);
    legacy_tbl(32'h30, 32'h4, 32'h00FF_FFFF);
    legacy_tbl(32'h60, 32'h0, 32'h0000_0007);
    discover(0);
    expect_ok("R5 msb ignored below rev 5", 32'd64, 32'h0020_0000, 8);
  endtask

  task automatic t_badsig();
    clear_img();
    put(0, 32'h5044_4654);
    discover(0);
    expect_err("R3 bad signature", 1);
  endtask

  task automatic t_none();
    clear_img();
    put(4, 32'hFF00_0100);
    put(8, 32'h0901_0001); put(12, 32'hFF00_0030);
    discover(0);
    expect_err("R6 no compatible table", 4);
    clear_img();
    put(4, 32'hFF00_0200);
    put(8, 32'h0901_0000); put(12, 32'hFF00_0030);
    discover(0);
    expect_err("R5 header area major 2", 4);
  endtask

  task automatic t_overflow();
    clear_img();
    put(4, 32'hFF00_0100);
    put(8, 32'h0901_0000); put(12, 32'hFF00_0030);
    legacy_tbl(32'h30, 32'h4, 32'h8000_0023);
    discover(0);
    expect_err("R10 overflow", 6);
    repeat (20) @(negedge clk);
    chk(!xfer_req && cfg_error && !cfg_valid, "R11 stays done",
        {30'd0, xfer_req, cfg_valid}, 32'd0);
    chk(capacity == DEFC, "R11 capacity held", capacity, DEFC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_legacy64(0);
    t_legacy64(1);
    t_legacy1();
    t_newrev();
    t_order();
    t_id_new();
    t_id_old();
    t_badsig();
    t_none();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule